// File: doc/BRIEF.md
# Iterative Feistel Round Core

This block is the data path of a 96-bit block cipher built as a balanced Feistel network. One round is computed per clock cycle. The state is two 48-bit halves, left and right, each made of six byte lanes. In each round one half, the source, is added lane by lane to a 48-bit round key. The sum passes through a bitsliced nonlinear layer that works on byte triples. The layer output is XORed into the other half, the target, together with a one-lane rotation of the target. The direction and the timing of that rotation depend on whether the core encrypts or decrypts.

A controller loads the input block and the mode on `start`. It then counts rounds up from 1 to `HALF_RNDS` and back down to 1, which gives `2*HALF_RNDS-1` rounds in total. It raises `done` for one cycle when the last round completes. The round keys come from an external key schedule, which is not part of this block. The core shows the schedule the current round number on `round_cnt` and shows which key half it uses on `key_sel`. The schedule presents both current key halves on `rk_right` and `rk_left`. The halves swap roles once the count turns down.

The controller has three states. `ST_IDLE` waits for `start`. `ST_UP` runs the rising rounds. `ST_DOWN` runs the falling rounds. The transitions are as follows:
- IDLE→UP on `start`, with the counter set to 1.
- UP→UP while the counter is below `HALF_RNDS`, incrementing it.
- UP→DOWN at `HALF_RNDS`, with the counter set to `HALF_RNDS-1`.
- DOWN→DOWN above 1, decrementing it.
- DOWN→IDLE at 1, with the counter cleared and `done` raised.

Top module: `feistel_round_core`

## Requirements
- R1: A synchronous `rst` clears the core, even in the middle of an operation. After reset `busy`=0, `done`=0, `dout`=0, `round_cnt`=0 and `key_sel`=0.
- R2: In idle, `start` loads `din` and `decrypt`. `din[95:48]` is the left half and `din[47:0]` is the right half. Lane i of a half is bits [8i+7:8i]. From the next cycle `busy` is 1 for exactly `2*HALF_RNDS-1` cycles, one round per cycle.
- R3: While busy, `round_cnt` shows the round about to be computed. It runs 1, 2, … `HALF_RNDS`, then `HALF_RNDS-1` down to 1.
- R4: `key_sel` selects the key half: 0 picks `rk_right` and 1 picks `rk_left`. It is 0 on odd counts in the rising phase and on even counts in the falling phase. It is 1 on even counts in the rising phase and on odd counts in the falling phase.
- R5: Key addition is a separate modulo-256 add in each byte lane, with no carry between lanes.
- R6: The layer works on each lane triple (x0,x1,x2), lanes 0–2 and lanes 3–5. It computes a=x0^(x1&x2), then b=x1^(a&x2), then c=x2^(a|b). Its outputs are a rotated right by one bit, b unchanged, and c rotated left by one bit.
- R7: When encrypting, the target is first rotated one lane upward (lane i→lane i+1, lane 5→lane 0) and the layer output is then XORed in.
- R8: When decrypting, the layer output is XORed into the unrotated target, and the result is rotated one lane downward (lane i+1→lane i, lane 0→lane 5).
- R9: Odd counts use the right half as source and update the left half. Even counts use the left half and update the right half. The source half is left unchanged.
- R10: `done` is high for exactly one cycle, the first cycle after the last round, with `busy` low in that cycle. `dout` then holds the result until the next accepted start.
- R11: `start` while busy is ignored, as are any changes on `din` and `decrypt`. The operation in progress finishes with an unchanged result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled in idle only) |
| decrypt | input | 1 | Mode: 0 encrypt, 1 decrypt; captured on start |
| din | input | 96 | Input block {left, right} |
| rk_right | input | 48 | Current right key half from the key schedule |
| rk_left | input | 48 | Current left key half from the key schedule |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 96 | State {left, right}; the result once done |
| round_cnt | output | 6 | Current round count, 0 in idle |
| key_sel | output | 1 | Key half used this round: 0 right, 1 left |

## Verification
The assertions take for granted that `rst` is a clean synchronous level. They also assume that the key schedule holds `rk_right` and `rk_left` settled before each clock edge, since the core samples them combinationally within the round. The stimulus meets both conditions. It changes inputs only a fixed time after a rising edge, and it keeps both key halves constant for a whole operation, so the bench model needs only the `key_sel` rule to know which key each round saw. Random blocks and keys in both modes are mixed with directed cases: the given check vector, lanes that wrap at 256, a start and mode change injected mid-run, and a reset in the middle of a run.

// File: rtl/feistel_pkg.sv
`timescale 1ns/1ps
package feistel_pkg;

    // Controller states of the round core
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } core_state_e;

endpackage

// File: rtl/lane_adder.sv
`timescale 1ns/1ps
// Lane-wise modular addition: each byte lane wraps on its own.
module lane_adder #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 6,
    localparam int HALF_W = BYTE_W * LANES
) (
    input  logic [HALF_W-1:0] op_a,
    input  logic [HALF_W-1:0] op_b,
    output logic [HALF_W-1:0] sum
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sum[i*BYTE_W +: BYTE_W] = op_a[i*BYTE_W +: BYTE_W] + op_b[i*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/bitslice_layer.sv
`timescale 1ns/1ps
// Bitsliced nonlinear layer applied to consecutive lane triples.
module bitslice_layer #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 6,
    localparam int HALF_W  = BYTE_W * LANES,
    localparam int TRIPLES = LANES / 3
) (
    input  logic [HALF_W-1:0] x_in,
    output logic [HALF_W-1:0] y_out
);

    for (genvar t = 0; t < TRIPLES; t++) begin : g_tri
        localparam int B0 = (3*t)     * BYTE_W;
        localparam int B1 = (3*t + 1) * BYTE_W;
        localparam int B2 = (3*t + 2) * BYTE_W;

        logic [BYTE_W-1:0] x0, x1, x2;
        logic [BYTE_W-1:0] sa, sb, sc;

        assign x0 = x_in[B0 +: BYTE_W];
        assign x1 = x_in[B1 +: BYTE_W];
        assign x2 = x_in[B2 +: BYTE_W];

        // serial dependency: each stage uses the one before
        assign sa = x0 ^ (x1 & x2);
        assign sb = x1 ^ (sa & x2);
        assign sc = x2 ^ (sa | sb);

        assign y_out[B0 +: BYTE_W] = {sa[0], sa[BYTE_W-1:1]};
        assign y_out[B1 +: BYTE_W] = sb;
        assign y_out[B2 +: BYTE_W] = {sc[BYTE_W-2:0], sc[BYTE_W-1]};
    end

endmodule

// File: rtl/half_mixer.sv
`timescale 1ns/1ps
// Combines layer output with the target half, including the lane rotation
// whose placement depends on the mode.
module half_mixer #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 6,
    localparam int HALF_W = BYTE_W * LANES
) (
    input  logic [HALF_W-1:0] tgt,
    input  logic [HALF_W-1:0] mix_in,
    input  logic              inverse,
    output logic [HALF_W-1:0] tgt_next
);

    logic [HALF_W-1:0] fwd_rot;
    logic [HALF_W-1:0] fwd_res;
    logic [HALF_W-1:0] inv_xor;
    logic [HALF_W-1:0] inv_res;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PREV = (i + LANES - 1) % LANES;
        localparam int NEXT = (i + 1) % LANES;
        // forward: rotate up first, then mix
        assign fwd_rot[i*BYTE_W +: BYTE_W] = tgt[PREV*BYTE_W +: BYTE_W];
        // inverse: mix first, then rotate down
        assign inv_res[i*BYTE_W +: BYTE_W] = inv_xor[NEXT*BYTE_W +: BYTE_W];
    end

    assign fwd_res  = fwd_rot ^ mix_in;
    assign inv_xor  = tgt ^ mix_in;
    assign tgt_next = inverse ? inv_res : fwd_res;

endmodule

// File: rtl/feistel_round_core.sv
`timescale 1ns/1ps
module feistel_round_core #(
    parameter int BYTE_W    = 8,
    parameter int LANES     = 6,   // must be a multiple of 3
    parameter int HALF_RNDS = 47,  // at least 2
    localparam int HALF_W   = BYTE_W * LANES,
    localparam int BLK_W    = 2 * HALF_W,
    localparam int CNT_W    = $clog2(HALF_RNDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              decrypt,
    input  logic [BLK_W-1:0]  din,
    input  logic [HALF_W-1:0] rk_right,
    input  logic [HALF_W-1:0] rk_left,
    output logic              busy,
    output logic              done,
    output logic [BLK_W-1:0]  dout,
    output logic [CNT_W-1:0]  round_cnt,
    output logic              key_sel
);

    import feistel_pkg::*;

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(HALF_RNDS);
    localparam logic [CNT_W-1:0] CNT_TURN = CNT_W'(HALF_RNDS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    core_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              dec_q;
    logic              done_q;
    logic [HALF_W-1:0] lq, rq;

    logic              odd_rnd;
    logic              in_down;
    logic              last_rnd;
    logic [HALF_W-1:0] src_half, tgt_half, rkey;
    logic [HALF_W-1:0] keyed, layered, mixed;

    assign odd_rnd  = cnt_q[0];
    assign in_down  = (state_q == ST_DOWN);
    assign last_rnd = in_down && (cnt_q == CNT_ONE);

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_UP;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_UP: begin
                if (cnt_q == CNT_TOP) begin
                    state_d = ST_DOWN;
                    cnt_d   = CNT_TURN;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_DOWN: begin
                if (cnt_q == CNT_ONE) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (state_q != ST_IDLE);
        // right key on rising odd / falling even rounds
        key_sel   = busy && (odd_rnd ^ !in_down);
        done      = done_q;
        dout      = {lq, rq};
        round_cnt = cnt_q;
    end

    // ---------------- round data path ----------------
    assign src_half = odd_rnd ? rq : lq;
    assign tgt_half = odd_rnd ? lq : rq;
    assign rkey     = key_sel ? rk_left : rk_right;

    lane_adder #(.BYTE_W(BYTE_W), .LANES(LANES)) u_add (
        .op_a (src_half),
        .op_b (rkey),
        .sum  (keyed)
    );

    bitslice_layer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_layer (
        .x_in  (keyed),
        .y_out (layered)
    );

    half_mixer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_mix (
        .tgt      (tgt_half),
        .mix_in   (layered),
        .inverse  (dec_q),
        .tgt_next (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lq     <= '0;
            rq     <= '0;
            dec_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_rnd;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    lq    <= din[BLK_W-1:HALF_W];
                    rq    <= din[HALF_W-1:0];
                    dec_q <= decrypt;
                end
            end else if (odd_rnd) begin
                lq <= mixed;
            end else begin
                rq <= mixed;
            end
        end
    end

    // ---------------- assertions ----------------
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q >= CNT_ONE && cnt_q <= CNT_TOP));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UP && cnt_q != CNT_TOP) |=>
            (state_q == ST_UP && cnt_q == $past(cnt_q) + CNT_ONE));

    // R3
    turn_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UP && cnt_q == CNT_TOP) |=>
            (state_q == ST_DOWN && cnt_q == CNT_TURN));

    // R9
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && odd_rnd) |=> $stable(rq));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy && cnt_q == '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dout));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dec_q));

endmodule

// File: tb/sim_feistel_round_core.sv
`timescale 1ns/1ps
module sim_feistel_round_core;

    localparam int HR = 47;
    localparam int NR = 2 * HR - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [95:0] din = '0;
    logic [47:0] rk_right = '0;
    logic [47:0] rk_left = '0;
    logic        busy, done, key_sel;
    logic [95:0] dout;
    logic [5:0]  round_cnt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    feistel_round_core u0 (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .din(din),
        .rk_right(rk_right), .rk_left(rk_left), .busy(busy), .done(done),
        .dout(dout), .round_cnt(round_cnt), .key_sel(key_sel)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one round on a 48-bit target, from the requirement text
    function automatic logic [47:0] mdl_round(input logic [47:0] src, input logic [47:0] tgt,
                                              input logic [47:0] key, input logic dec);
        logic [7:0] s [6];
        logic [7:0] f [6];
        logic [7:0] t [6];
        logic [7:0] a, b, c;
        logic [47:0] r;
        for (int i = 0; i < 6; i++) s[i] = src[8*i +: 8] + key[8*i +: 8];
        for (int g = 0; g < 2; g++) begin
            a = s[3*g] ^ (s[3*g+1] & s[3*g+2]);
            b = s[3*g+1] ^ (a & s[3*g+2]);
            c = s[3*g+2] ^ (a | b);
            f[3*g]   = {a[0], a[7:1]};
            f[3*g+1] = b;
            f[3*g+2] = {c[6:0], c[7]};
        end
        for (int i = 0; i < 6; i++) t[i] = dec ? tgt[8*i +: 8] : tgt[8*((i+5)%6) +: 8];
        for (int i = 0; i < 6; i++) t[i] = t[i] ^ f[i];
        for (int i = 0; i < 6; i++) r[8*i +: 8] = dec ? t[(i+1)%6] : t[i];
        return r;
    endfunction

    function automatic logic [95:0] mdl_full(input logic [95:0] d, input logic dec,
                                             input logic [47:0] kr, input logic [47:0] kl);
        logic [47:0] lh, rh, k;
        bit up, odd;
        lh = d[95:48];
        rh = d[47:0];
        for (int r = 1; r <= NR; r++) begin
            up  = (r <= HR);
            odd = (r % 2 == 1);
            k   = (odd ^ up) ? kl : kr;
            if (odd) lh = mdl_round(rh, lh, k, dec);
            else     rh = mdl_round(lh, rh, k, dec);
        end
        return {lh, rh};
    endfunction

    function automatic int exp_cnt(input int r);
        return (r <= HR) ? r : 2 * HR - r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_op(input logic [95:0] d, input logic dec, input logic [47:0] kr,
                          input logic [47:0] kl, input bit poke, input string tag1);
        logic [95:0] expf, exp1, hold;
        expf = mdl_full(d, dec, kr, kl);
        exp1 = {mdl_round(d[47:0], d[95:48], kr, dec), d[47:0]};
        din = d; decrypt = dec; rk_right = kr; rk_left = kl; start = 1'b1;
        tick();
        start = 1'b0;
        for (int r = 1; r <= NR; r++) begin
            chk(busy === 1'b1, "R2 busy during run", {95'd0, busy}, 96'd1);
            chk(round_cnt == 6'(exp_cnt(r)), "R3 round count", {90'd0, round_cnt}, 96'(exp_cnt(r)));
            chk(key_sel == ((r % 2 == 1) ^ (r <= HR)), "R4 key half",
                {95'd0, key_sel}, 96'((r % 2 == 1) ^ (r <= HR)));
            if (poke && r == 40) begin
                start = 1'b1; din = ~d; decrypt = ~dec;
            end
            tick();
            start = 1'b0;
            if (r == 1) chk(dout == exp1, tag1, dout, exp1);
        end
        chk(done === 1'b1 && busy === 1'b0, "R10 done pulse with busy low", {94'd0, done, busy}, 96'b10);
        chk(dout == expf, poke ? "R11 result after ignored start" : "R6 R9 final result", dout, expf);
        hold = dout;
        tick();
        chk(done === 1'b0 && busy === 1'b0, "R10 done drops", {94'd0, done, busy}, 96'd0);
        chk(dout == hold, "R10 result held", dout, hold);
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [95:0] rd;
        logic [47:0] k1, k2;
        void'($urandom(32'd20240607));
        // reset state
        tick(); tick(); tick();
        chk(busy === 1'b0 && done === 1'b0 && key_sel === 1'b0, "R1 reset flags",
            {93'd0, busy, done, key_sel}, 96'd0);
        chk(dout === 96'd0, "R1 reset data", dout, 96'd0);
        chk(round_cnt === 6'd0, "R1 reset count", {90'd0, round_cnt}, 96'd0);
        rst = 1'b0;
        tick();
        chk(busy === 1'b0 && dout === 96'd0, "R1 idle after reset", dout, 96'd0);

        // directed check vector, encryption
        run_op({48'h0, 48'h000000000001}, 1'b0, 48'h000000000001, 48'h0, 1'b0, "R7 first encrypt round");
        // same vector, decryption
        run_op({48'h0, 48'h000000000001}, 1'b1, 48'h000000000001, 48'h0, 1'b0, "R8 first decrypt round");
        // lane wrap: every lane sums to 0x100, no carry into the next lane
        run_op({48'h123456789abc, 48'hffffffffffff}, 1'b0, 48'h010101010101, 48'h0f0f0f0f0f0f, 1'b0,
               "R5 lane wrap encrypt");
        run_op({48'hfedcba987654, 48'hff80ff80ff80}, 1'b1, 48'h018001800180, 48'hffffffffffff, 1'b0,
               "R5 lane wrap decrypt");
        // start during a run is ignored
        run_op({48'hdeadbeef0102, 48'h0a0b0c0d0e0f}, 1'b0, 48'h55aa55aa55aa, 48'h3c3c3c3c3c3c, 1'b1,
               "R7 first round before ignored start");
        run_op({48'h0a0b0c0d0e0f, 48'hdeadbeef0102}, 1'b1, 48'h13579bdf0246, 48'h8ace02468ace, 1'b1,
               "R8 first round before ignored start");

        // random operations, both modes
        for (int n = 0; n < 10; n++) begin
            rd = {$urandom(), $urandom(), $urandom()};
            k1 = {$urandom(), $urandom()};
            k2 = {$urandom(), $urandom()};
            run_op(rd, n[0], k1, k2, 1'b0, n[0] ? "R8 random first round" : "R7 random first round");
        end

        // reset in the middle of a run
        din = {$urandom(), $urandom(), $urandom()};
        decrypt = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        rst = 1'b1;
        tick();
        chk(busy === 1'b0 && done === 1'b0, "R1 mid-run reset flags", {94'd0, busy, done}, 96'd0);
        chk(dout === 96'd0 && round_cnt === 6'd0, "R1 mid-run reset state", dout, 96'd0);
        rst = 1'b0;
        tick();
        run_op({48'h0, 48'h000000000001}, 1'b0, 48'h000000000001, 48'h0, 1'b0, "R7 run after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule